// File: doc/BRIEF.md
# Debug Watchpoint Comparator Unit

This block watches three buses of a processor: the instruction-fetch address, the load/store address and the load/store data value. It does so through eight programmable comparators: four on the fetch address, two on the load/store address and two on the data value. Each comparator holds a reference value, one of four unsigned relations (equal, not equal, less than, greater than) and an enable bit. A comparator result counts only on a cycle where its bus is qualified by its valid input.

Six watchpoint outputs come from the comparator results. Watchpoints 0 to 3 each follow one fetch-address comparator. Watchpoints 4 and 5 each need a load/store address comparator and a data comparator to match on the same access. Every watchpoint has an occurrence counter that can turn it into a breakpoint request after a programmed number of hits. The counter reloads after it fires, so the request repeats every N hits.

The unit only observes the buses. It has no stall path, and its outputs follow a qualified cycle after one register stage. Software programs it through a simple write port.

Top module: `dbg_wpt_unit`

## Requirements
- R1: A comparator applies the relation held in control bits [1:0] (0 equal, 1 not equal, 2 less than, 3 greater than) between the bus value and its reference, both taken as unsigned, and control bit 2 enables it.
- R2: Watchpoint w (w = 0..3) is high in the cycle after a fetch cycle (if_valid high) in which fetch comparator w is enabled and its relation holds.
- R3: A watchpoint never rises for a cycle whose bus valid input was low, nor from a disabled comparator.
- R4: Watchpoint 4+j (j = 0, 1) is high in the cycle after a load/store cycle (ls_valid high) only when address comparator 4+j matches ls_addr and data comparator 6+j matches ls_data in that same cycle.
- R5: With a nonzero count N programmed for watchpoint w, brk_o is high in the same cycle as the N-th high cycle of that watchpoint's output.
- R6: After a breakpoint fires, the count reloads, so the next breakpoint from that watchpoint comes after a further N hits.
- R7: A count of zero means that watchpoint never raises brk_o, while its watchpoint output still works.
- R8: Writing a count restarts the countdown from the new value. A hit in the same cycle as that write is not counted.
- R9: Register select values (cfg_addr): 0..7 write the reference of comparator k, 8..15 write the control of comparator k-8, and 16..21 write the count of watchpoint k-16. Comparators 0..3 are on the fetch address, 4..5 on the load/store address and 6..7 on the data value.
- R10: After reset all comparators are disabled, all counts are zero, and wp_o and brk_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register select |
| cfg_wdata | input | max(AW,DW) | Register write data |
| if_valid | input | 1 | Fetch address qualifier |
| if_addr | input | AW | Fetch address |
| ls_valid | input | 1 | Load/store access qualifier |
| ls_addr | input | AW | Load/store address |
| ls_data | input | DW | Load/store data value |
| wp_o | output | 6 | Watchpoint outputs, one cycle after the qualified bus cycle |
| brk_o | output | 1 | Breakpoint request |

## Verification
A corrupted reference, relation or enable bit shows on wp_o one cycle after the first qualified bus value that falls on the wrong side of the reference. For this reason the bench sweeps every bus value for each relation. An occurrence counter that is off by one, or that fails to reload, stays invisible until the N-th hit. It then shows as a brk_o that comes early, comes late or does not come back. The bench therefore runs hit streams long enough to cover at least two full periods of each count it programs.

// File: rtl/dbg_wpt_pkg.sv
`timescale 1ns/1ps
package dbg_wpt_pkg;
   typedef enum logic [1:0] {
      CMP_EQ = 2'd0,
      CMP_NE = 2'd1,
      CMP_LT = 2'd2,
      CMP_GT = 2'd3
   } cmp_rel_e;

   localparam int N_ICMP    = 4;            // fetch-address comparators
   localparam int N_DPAIR   = 2;            // address/data comparator pairs
   localparam int N_CMP     = N_ICMP + 2 * N_DPAIR;
   localparam int N_WP      = N_ICMP + N_DPAIR;
   localparam int SEL_W     = 5;
   localparam int REF_BASE  = 0;
   localparam int CTL_BASE  = REF_BASE + N_CMP;
   localparam int CNT_BASE  = CTL_BASE + N_CMP;
   localparam int CTL_EN    = 2;
endpackage

// File: rtl/dbg_wpt_cmp.sv
`timescale 1ns/1ps
module dbg_wpt_cmp
   import dbg_wpt_pkg::*;
#(
   parameter int W     = 32,
   parameter int CFG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ref,
   input  logic             wr_ctl,
   input  logic [CFG_W-1:0] wdata,
   input  logic             qual,
   input  logic [W-1:0]     opnd,
   output logic             hit
);
   logic [W-1:0] ref_q;
   cmp_rel_e     rel_q;
   logic         en_q;
   logic         rel_ok;
   logic [W-1:0] ref_d;

   generate
      if (W == CFG_W) begin : g_full
         assign ref_d = wdata;
      end else begin : g_slice
         assign ref_d = wdata[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '0;
         rel_q <= CMP_EQ;
         en_q  <= 1'b0;
      end else begin
         if (wr_ref) ref_q <= ref_d;
         if (wr_ctl) begin
            rel_q <= cmp_rel_e'(wdata[1:0]);
            en_q  <= wdata[CTL_EN];
         end
      end
   end

   always_comb begin
      case (rel_q)
         CMP_EQ:  rel_ok = (opnd == ref_q);
         CMP_NE:  rel_ok = (opnd != ref_q);
         CMP_LT:  rel_ok = (opnd <  ref_q);
         default: rel_ok = (opnd >  ref_q);
      endcase
   end

   assign hit = qual & en_q & rel_ok;
endmodule

// File: rtl/dbg_wpt_evcnt.sv
`timescale 1ns/1ps
module dbg_wpt_evcnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             ev,
   output logic             fire
);
   logic [CNT_W-1:0] limit_q;
   logic [CNT_W-1:0] left_q;
   logic             armed;

   assign armed = (limit_q != '0);
   assign fire  = ev & ~wr & armed & (left_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q <= '0;
         left_q  <= '0;
      end else if (wr) begin
         limit_q <= wdata;
         left_q  <= wdata;
      end else if (ev && armed) begin
         if (left_q <= CNT_W'(1)) left_q <= limit_q;
         else                     left_q <= left_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/dbg_wpt_unit.sv
`timescale 1ns/1ps
module dbg_wpt_unit
   import dbg_wpt_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int CNT_W = 8,
   localparam int CFG_W = (AW > DW) ? AW : DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_addr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             if_valid,
   input  logic [AW-1:0]    if_addr,
   input  logic             ls_valid,
   input  logic [AW-1:0]    ls_addr,
   input  logic [DW-1:0]    ls_data,
   output logic [N_WP-1:0]  wp_o,
   output logic             brk_o
);
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("dbg_wpt_unit: bus widths must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > CFG_W) begin : g_bad_cnt
      $error("dbg_wpt_unit: CNT_W must lie in 1..max(AW,DW)");
   end
   if (CNT_BASE + N_WP > (1 << SEL_W)) begin : g_bad_map
      $error("dbg_wpt_unit: register map exceeds select width");
   end

   logic [N_ICMP-1:0]  i_hit;
   logic [N_DPAIR-1:0] a_hit;
   logic [N_DPAIR-1:0] d_hit;
   logic [N_WP-1:0]    wp_hit;
   logic [N_WP-1:0]    fire;

   function automatic logic sel(input logic [SEL_W-1:0] a, input int idx);
      return cfg_we && (a == SEL_W'(idx));
   endfunction

   for (genvar i = 0; i < N_ICMP; i++) begin : g_icmp
      dbg_wpt_cmp #(.W(AW), .CFG_W(CFG_W)) u_cmp (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_ref (sel(cfg_addr, REF_BASE + i)),
         .wr_ctl (sel(cfg_addr, CTL_BASE + i)),
         .wdata  (cfg_wdata),
         .qual   (if_valid),
         .opnd   (if_addr),
         .hit    (i_hit[i])
      );
   end

   for (genvar j = 0; j < N_DPAIR; j++) begin : g_dpair
      dbg_wpt_cmp #(.W(AW), .CFG_W(CFG_W)) u_acmp (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_ref (sel(cfg_addr, REF_BASE + N_ICMP + j)),
         .wr_ctl (sel(cfg_addr, CTL_BASE + N_ICMP + j)),
         .wdata  (cfg_wdata),
         .qual   (ls_valid),
         .opnd   (ls_addr),
         .hit    (a_hit[j])
      );
      dbg_wpt_cmp #(.W(DW), .CFG_W(CFG_W)) u_dcmp (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_ref (sel(cfg_addr, REF_BASE + N_ICMP + N_DPAIR + j)),
         .wr_ctl (sel(cfg_addr, CTL_BASE + N_ICMP + N_DPAIR + j)),
         .wdata  (cfg_wdata),
         .qual   (ls_valid),
         .opnd   (ls_data),
         .hit    (d_hit[j])
      );
   end

   assign wp_hit = {a_hit & d_hit, i_hit};

   for (genvar w = 0; w < N_WP; w++) begin : g_cnt
      dbg_wpt_evcnt #(.CNT_W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (sel(cfg_addr, CNT_BASE + w)),
         .wdata (cfg_wdata[CNT_W-1:0]),
         .ev    (wp_hit[w]),
         .fire  (fire[w])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_o  <= '0;
         brk_o <= 1'b0;
      end else begin
         wp_o  <= wp_hit;
         brk_o <= |fire;
      end
   end
endmodule

// File: rtl/dbg_wpt_chk.sv
`timescale 1ns/1ps
module dbg_wpt_chk
   import dbg_wpt_pkg::*;
#(
   parameter int CFG_W = 32,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [SEL_W-1:0] cfg_addr,
   input logic [CFG_W-1:0] cfg_wdata,
   input logic             if_valid,
   input logic             ls_valid,
   input logic [N_WP-1:0]  wp_o,
   input logic             brk_o
);
   logic [N_WP-1:0] armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= '0;
      else begin
         for (int w = 0; w < N_WP; w++) begin
            if (cfg_we && cfg_addr == SEL_W'(CNT_BASE + w))
               armed_q[w] <= |cfg_wdata[CNT_W-1:0];
         end
      end
   end

   AST_IWP_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      |wp_o[N_ICMP-1:0] |-> $past(if_valid));                  // R3
   AST_DWP_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      |wp_o[N_WP-1:N_ICMP] |-> $past(ls_valid));               // R4
   AST_BRK_WITH_WP: assert property (@(posedge clk) disable iff (!rst_n)
      brk_o |-> |wp_o);                                         // R5
   AST_ZERO_COUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      brk_o |-> |($past(armed_q) & wp_o));                      // R7
   AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (!if_valid && !ls_valid) |=> (wp_o == '0 && !brk_o));     // R2
endmodule

bind dbg_wpt_unit dbg_wpt_chk #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .if_valid  (if_valid),
   .ls_valid  (ls_valid),
   .wp_o      (wp_o),
   .brk_o     (brk_o)
);

// File: tb/dbg_wpt_unit_tb.sv
`timescale 1ns/1ps
module dbg_wpt_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [4:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       if_valid = 1'b0;
   logic [7:0] if_addr = '0;
   logic       ls_valid = 1'b0;
   logic [7:0] ls_addr = '0;
   logic [7:0] ls_data = '0;
   logic [5:0] wp_o;
   logic       brk_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   dbg_wpt_unit #(.AW(8), .DW(8), .CNT_W(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .if_valid(if_valid), .if_addr(if_addr),
      .ls_valid(ls_valid), .ls_addr(ls_addr), .ls_data(ls_data),
      .wp_o(wp_o), .brk_o(brk_o));

   always #2.5 clk = ~clk;

   function automatic logic rel(input int c, input int x, input int r);
      case (c)
         0: return x == r;
         1: return x != r;
         2: return x < r;
         default: return x > r;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      if_valid = 0; ls_valid = 0;
      cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
      @(posedge clk); #1;
      cfg_we = 0;
   endtask

   task automatic ctl(input int k, input int en, input int c);
      wr(8 + k, (en << 2) | c);
   endtask

   task automatic step(input logic iv, input int ia, input logic lv,
                       input int la, input int ld);
      @(negedge clk);
      cfg_we = 0;
      if_valid = iv; if_addr = 8'(ia);
      ls_valid = lv; ls_addr = 8'(la); ls_data = 8'(ld);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int hits;
      repeat (3) @(posedge clk);
      #1;
      check("R10 wp reset", int'(wp_o), 0);
      check("R10 brk reset", int'(brk_o), 0);
      @(negedge clk); rst_n = 1;
      // R10: all comparators disabled after reset, reference 0 / equal
      step(1, 0, 1, 0, 0);
      check("R10 disabled after reset", int'(wp_o), 0);
      check("R10 no brk after reset", int'(brk_o), 0);

      // R1 R2: full sweep of each relation on fetch comparator 0
      wr(0, 100);
      for (int c = 0; c < 4; c++) begin
         ctl(0, 1, c);
         for (int a = 0; a < 256; a++) begin
            step(1, a, 0, 0, 0);
            check("R1 relation sweep", int'(wp_o), int'(rel(c, a, 100)));
            check("R7 no brk with zero count", int'(brk_o), 0);
         end
      end

      // R9 R2: all four fetch comparators, distinct registers
      wr(0, 100); ctl(0, 1, 0);
      wr(1, 10);  ctl(1, 1, 2);
      wr(2, 250); ctl(2, 1, 3);
      wr(3, 7);   ctl(3, 1, 1);
      for (int a = 0; a < 256; a++) begin
         int e;
         step(1, a, 0, 0, 0);
         e = int'(rel(0, a, 100)) | (int'(rel(2, a, 10)) << 1)
           | (int'(rel(3, a, 250)) << 2) | (int'(rel(1, a, 7)) << 3);
         check("R9 R2 fetch map", int'(wp_o), e);
      end
      // R3: invalid fetch cycles never match
      for (int a = 0; a < 256; a++) begin
         step(0, a, 0, 0, 0);
         check("R3 fetch invalid", int'(wp_o), 0);
      end
      ctl(3, 0, 1);
      step(1, 3, 0, 0, 0);
      check("R3 disabled comparator", int'(wp_o[3]), 0);
      check("R3 others still live", int'(wp_o[1]), 1);

      // R4: data watchpoints need address and data match together
      wr(4, 8'h40); ctl(4, 1, 0);
      wr(6, 8'h80); ctl(6, 1, 3);
      wr(5, 8'h10); ctl(5, 1, 2);
      wr(7, 8'h55); ctl(7, 1, 1);
      for (int s = 0; s < 3; s++) begin
         int la;
         la = (s == 0) ? 8'h40 : (s == 1) ? 8'h05 : 8'h41;
         for (int d = 0; d < 256; d++) begin
            int e;
            step(0, 0, 1, la, d);
            e = ((int'(rel(0, la, 8'h40)) & int'(rel(3, d, 8'h80))) << 4)
              | ((int'(rel(2, la, 8'h10)) & int'(rel(1, d, 8'h55))) << 5);
            check("R4 pair sweep", int'(wp_o), e);
         end
      end
      step(0, 0, 0, 8'h40, 8'h90);
      check("R3 R4 access invalid", int'(wp_o), 0);
      ctl(6, 0, 3);
      step(0, 0, 1, 8'h40, 8'h90);
      check("R4 data half disabled", int'(wp_o[4]), 0);
      ctl(6, 1, 3);

      // R5 R6: count 3 on watchpoint 0, hits at 100 with misses between
      wr(16, 3);
      hits = 0;
      for (int n = 0; n < 14; n++) begin
         if (n % 2 == 0) begin
            step(1, 100, 0, 0, 0);
            hits++;
            check("R5 hit seen", int'(wp_o[0]), 1);
            check("R6 brk on every 3rd hit", int'(brk_o), int'(hits % 3 == 0));
         end else begin
            step(1, 50, 0, 0, 0);
            check("R5 no brk on miss", int'(brk_o), 0);
         end
      end
      // R7: count zero silences the breakpoint only
      wr(16, 0);
      for (int n = 0; n < 5; n++) begin
         step(1, 100, 0, 0, 0);
         check("R7 wp still high", int'(wp_o[0]), 1);
         check("R7 zero count", int'(brk_o), 0);
      end
      // R8: rewrite restarts the countdown
      wr(16, 4);
      step(1, 100, 0, 0, 0);
      step(1, 100, 0, 0, 0);
      check("R8 before rewrite", int'(brk_o), 0);
      wr(16, 4);
      for (int n = 1; n <= 4; n++) begin
         step(1, 100, 0, 0, 0);
         check("R8 count from rewrite", int'(brk_o), int'(n == 4));
      end
      // R8: a hit during the count write is not counted
      wr(16, 2);
      @(negedge clk);
      cfg_we = 1; cfg_addr = 5'd16; cfg_wdata = 8'd2;
      if_valid = 1; if_addr = 8'd100;
      @(posedge clk); #1;
      check("R8 write wins over hit", int'(brk_o), 0);
      step(1, 100, 0, 0, 0);
      check("R8 first counted hit", int'(brk_o), 0);
      step(1, 100, 0, 0, 0);
      check("R8 second counted hit", int'(brk_o), 1);
      wr(16, 0);

      // R5: data watchpoint count 2
      wr(20, 2);
      for (int n = 1; n <= 4; n++) begin
         step(0, 0, 1, 8'h40, 8'h90);
         check("R5 data wp", int'(wp_o), 6'b010000);
         check("R5 data brk", int'(brk_o), int'(n % 2 == 0));
      end
      // R5: two watchpoints firing together
      wr(16, 1); wr(20, 1);
      step(1, 100, 1, 8'h40, 8'h90);
      check("R5 joint wp", int'(wp_o), 6'b010001);
      check("R5 joint brk", int'(brk_o), 1);
      step(0, 0, 0, 0, 0);
      check("R2 idle clears", int'(wp_o), 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule